// File: doc/BRIEF.md
# Peripheral Soft-Reset and Clock-Gate Control Slice

This block is one control word for a single peripheral. It holds a soft-reset bit, a clock-gate bit, an enable bit and a two-bit data bus width field. Software reaches the word at three addresses. A plain address replaces the whole word. A set alias turns on only the bits written as 1. A clear alias turns off only the bits written as 1. The slice drives a reset line into the peripheral core and an enable for an external clock-gating cell.

Software resets the peripheral with a polled handshake. It sets soft reset, and the slice holds the core in reset. A fixed number of cycles later the slice raises the clock gate by itself, and software polls until it reads that gate as 1. Software then releases soft reset. The gate stays set until software clears it, and the clock runs again once the gate reads 0. While soft reset is set, the enable bit and the width field read as zero and ignore writes.

Top module: `pctl_top`

## Requirements
- R1: After reset the control word reads 0x00000000, the core reset output is low and the clock enable output is high.
- R2: A write to offset 0x0 replaces the whole word. Bit 31 is soft reset, bit 30 is the clock gate, bits 2:1 are the width field and bit 0 is enable. All other bits read 0.
- R3: A write to offset 0x4 sets each field bit written as 1 and leaves every other bit unchanged.
- R4: A write to offset 0x8 clears each field bit written as 1 and leaves every other bit unchanged.
- R5: Soft reset goes to 1 on a write edge. The clock gate then reads 0 after that edge and after the next three edges, and reads 1 from the fourth edge after it.
- R6: The core reset output is high in every cycle in which soft reset reads 1, and low otherwise.
- R7: While soft reset is 1, the enable bit and the width field read 0 and writes to them have no effect. After soft reset is released, writes to them take effect again.
- R8: Clearing soft reset leaves the clock gate at 1. The gate reads 1 until software clears it.
- R9: The clock enable output is low whenever the clock gate reads 1, and high whenever it reads 0.
- R10: The width field stores and reads back code 0 (1-bit), 1 (4-bit) and 2 (8-bit).
- R11: Offsets 0x4 and 0x8 read back the control word. Any other offset reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_rst | output | 1 | Reset to the peripheral core, active high |
| clk_en | output | 1 | Enable for the external clock-gating cell |

## Verification
The assertions run on every cycle. They check that a set-alias write leaves the clock gate alone, that a clear-alias write drops soft reset, that the enable and width fields stay cleared and read as zero during soft reset, and that the gate rises only under soft reset or on a write. The exact four-edge delay before the gate rises, the masked readback at each polling step of the full handshake, the gate staying set after release, and the clock enable's relation to the gate can only be shown by the bench scenarios, which compare polled reads against values computed from the requirements.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
   localparam int CW        = 32;
   localparam int BIT_SRST  = 31;
   localparam int BIT_CGATE = 30;
   localparam int BIT_EN    = 0;
   localparam int WID_LSB   = 1;
   localparam int WID_W     = 2;
   localparam int OFS_WORD  = 0;
   localparam int OFS_SET   = 4;
   localparam int OFS_CLR   = 8;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_WORD = 2'd1,
      ACC_SET  = 2'd2,
      ACC_CLR  = 2'd3
   } acc_e;
endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
   import pctl_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_e              kind
);
   always_comb begin
      if (addr == ADDR_W'(OFS_WORD))      kind = ACC_WORD;
      else if (addr == ADDR_W'(OFS_SET))  kind = ACC_SET;
      else if (addr == ADDR_W'(OFS_CLR))  kind = ACC_CLR;
      else                                kind = ACC_NONE;
   end
endmodule

// File: rtl/pctl_gate_timer.sv
module pctl_gate_timer #(
   parameter int GATE_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   output logic gate_set,
   output logic core_rst
);
   localparam int CNT_W = $clog2(GATE_DLY + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!srst)
         cnt_q <= '0;
      else if (cnt_q < CNT_W'(GATE_DLY))
         cnt_q <= cnt_q + 1'b1;
   end

   assign gate_set = srst && (cnt_q == CNT_W'(GATE_DLY - 1));
   assign core_rst = srst;
endmodule

// File: rtl/pctl_regs.sv
module pctl_regs
   import pctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  acc_e              kind,
   input  logic [CW-1:0]     wdata,
   input  logic              gate_set,
   output logic              srst_q,
   output logic              gate_q,
   output logic              en_q,
   output logic [WID_W-1:0]  wid_q
);
   logic [CW-1:0] cur, nxt;

   always_comb begin
      cur = '0;
      cur[BIT_SRST]  = srst_q;
      cur[BIT_CGATE] = gate_q;
      cur[BIT_EN]    = en_q;
      cur[WID_LSB +: WID_W] = wid_q;
      nxt = cur;
      if (we) begin
         case (kind)
            ACC_WORD: nxt = wdata;
            ACC_SET:  nxt = cur | wdata;
            ACC_CLR:  nxt = cur & ~wdata;
            default:  nxt = cur;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         gate_q <= 1'b0;
         en_q   <= 1'b0;
         wid_q  <= '0;
      end else begin
         srst_q <= nxt[BIT_SRST];
         gate_q <= nxt[BIT_CGATE] | gate_set;
         if (srst_q) begin
            en_q  <= 1'b0;
            wid_q <= '0;
         end else begin
            en_q  <= nxt[BIT_EN];
            wid_q <= nxt[WID_LSB +: WID_W];
         end
      end
   end

   // R3: a set-alias write without the gate bit leaves the gate as it was
   p_set_keeps_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && kind == ACC_SET && !wdata[BIT_CGATE] && !gate_set) |=> (gate_q == $past(gate_q)));

   // R4: a clear-alias write of the soft reset bit drops it
   p_clr_drops_srst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && kind == ACC_CLR && wdata[BIT_SRST]) |=> !srst_q);

   // R7: fields are held cleared while soft reset is active
   p_fields_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (!en_q && wid_q == '0));
endmodule

// File: rtl/pctl_readback.sv
module pctl_readback
   import pctl_pkg::*;
#(
   parameter bit ALIAS_READ = 1'b1
) (
   input  acc_e              kind,
   input  logic              srst_q,
   input  logic              gate_q,
   input  logic              en_q,
   input  logic [WID_W-1:0]  wid_q,
   output logic [CW-1:0]     rdata
);
   logic [CW-1:0] word;
   logic          hit;

   always_comb begin
      word = '0;
      word[BIT_SRST]  = srst_q;
      word[BIT_CGATE] = gate_q;
      word[BIT_EN]    = en_q & ~srst_q;
      word[WID_LSB +: WID_W] = srst_q ? '0 : wid_q;
   end

   generate
      if (ALIAS_READ) begin : g_alias_rd
         assign hit = (kind != ACC_NONE);
      end else begin : g_plain_rd
         assign hit = (kind == ACC_WORD);
      end
   endgenerate

   assign rdata = hit ? word : '0;
endmodule

// File: rtl/pctl_top.sv
module pctl_top
   import pctl_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int GATE_DLY   = 4,
   parameter bit ALIAS_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CW-1:0]     bus_wdata,
   input  logic              bus_we,
   output logic [CW-1:0]     bus_rdata,
   output logic              core_rst,
   output logic              clk_en
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pctl_top: ADDR_W must reach offset 0x8");
      end
      if (GATE_DLY < 1) begin : g_bad_dly
         $error("pctl_top: GATE_DLY must be at least 1");
      end
   endgenerate

   acc_e             kind;
   logic             gate_set;
   logic             srst_q, gate_q, en_q;
   logic [WID_W-1:0] wid_q;

   pctl_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .kind (kind)
   );

   pctl_gate_timer #(.GATE_DLY(GATE_DLY)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst_q),
      .gate_set (gate_set),
      .core_rst (core_rst)
   );

   pctl_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .kind     (kind),
      .wdata    (bus_wdata),
      .gate_set (gate_set),
      .srst_q   (srst_q),
      .gate_q   (gate_q),
      .en_q     (en_q),
      .wid_q    (wid_q)
   );

   pctl_readback #(.ALIAS_READ(ALIAS_READ)) u_rb (
      .kind   (kind),
      .srst_q (srst_q),
      .gate_q (gate_q),
      .en_q   (en_q),
      .wid_q  (wid_q),
      .rdata  (bus_rdata)
   );

   assign clk_en = ~gate_q;

   // R5: the gate rises only under soft reset or from a software write
   p_gate_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> (srst_q || $past(bus_we)));

   // R7: plain-address reads show cleared fields during soft reset
   p_mask_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q && kind == ACC_WORD) |-> (bus_rdata[BIT_EN] == 1'b0 &&
                                        bus_rdata[WID_LSB +: WID_W] == '0));
endmodule

// File: tb/pctl_top_tb.sv
module pctl_top_tb;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_rdata;
   logic          core_rst, clk_en;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] rd;
      logic        crst;
      logic        cen;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   event smp_ev;

   always #10 clk = ~clk;   // 50 MHz

   pctl_top #(.ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .core_rst  (core_rst),
      .clk_en    (clk_en)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(smp_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (bus_rdata !== e.rd || core_rst !== e.crst || clk_en !== e.cen) begin
               n_errors++;
               $display("FAIL %s: rdata=%h core_rst=%b clk_en=%b expected rdata=%h core_rst=%b clk_en=%b",
                        e.tag, bus_rdata, core_rst, clk_en, e.rd, e.crst, e.cen);
            end
         end
      end
   end

   // all tasks start and end just after a falling edge
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic chk(input logic [AW-1:0] a, input logic [31:0] rd,
                      input logic crst, input logic cen, input string tag);
      exp_t e;
      bus_addr = a;
      #1;
      e.rd = rd; e.crst = crst; e.cen = cen; e.tag = tag;
      exp_q.push_back(e);
      ->smp_ev;
      #1;
   endtask

   localparam logic [31:0] SR = 32'h8000_0000;
   localparam logic [31:0] CG = 32'h4000_0000;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk(4'h0, 32'h0, 1'b0, 1'b1, "R1 reset state");

      wr(4'h0, 32'h3);
      chk(4'h0, 32'h3, 1'b0, 1'b1, "R2 R10 plain write en+width 4-bit");
      wr(4'h0, 32'h4);
      chk(4'h0, 32'h4, 1'b0, 1'b1, "R2 R10 plain replace width 8-bit");
      wr(4'h4, 32'h1);
      chk(4'h0, 32'h5, 1'b0, 1'b1, "R3 set alias enable");
      wr(4'h8, 32'h4);
      chk(4'h0, 32'h1, 1'b0, 1'b1, "R4 R10 clear alias width to 1-bit");

      wr(4'hC, 32'hFFFF_FFFF);
      chk(4'hC, 32'h0, 1'b0, 1'b1, "R11 unmapped reads zero");
      chk(4'h0, 32'h1, 1'b0, 1'b1, "R11 unmapped write ignored");
      chk(4'h4, 32'h1, 1'b0, 1'b1, "R11 set alias reads word");
      chk(4'h8, 32'h1, 1'b0, 1'b1, "R11 clear alias reads word");

      // handshake preparation
      wr(4'h8, SR);
      repeat (3) tick();
      wr(4'h8, CG);
      chk(4'h0, 32'h1, 1'b0, 1'b1, "R4 prep clears leave enable");

      // assert soft reset, poll the gate
      wr(4'h4, SR);
      chk(4'h0, SR, 1'b1, 1'b1, "R5 R6 R7 edge0 gate low, fields masked");
      tick();
      chk(4'h0, SR, 1'b1, 1'b1, "R5 edge1 gate low");
      tick();
      chk(4'h0, SR, 1'b1, 1'b1, "R5 edge2 gate low");
      tick();
      chk(4'h0, SR, 1'b1, 1'b1, "R5 edge3 gate low");
      tick();
      chk(4'h0, SR | CG, 1'b1, 1'b0, "R5 R9 edge4 gate high");

      wr(4'h4, 32'h7);
      chk(4'h0, SR | CG, 1'b1, 1'b0, "R7 field writes ignored in reset");

      // release soft reset
      wr(4'h8, SR);
      chk(4'h0, CG, 1'b0, 1'b0, "R8 R6 release keeps gate");
      wr(4'h4, 32'h1);
      chk(4'h0, CG | 32'h1, 1'b0, 1'b0, "R7 writes work after release");
      repeat (3) tick();
      chk(4'h0, CG | 32'h1, 1'b0, 1'b0, "R8 gate still held");
      wr(4'h8, CG);
      chk(4'h0, 32'h1, 1'b0, 1'b1, "R8 R9 software clears gate");

      wr(4'h0, CG);
      chk(4'h0, CG, 1'b0, 1'b0, "R9 software gate via plain write");
      wr(4'h0, 32'h0);
      chk(4'h0, 32'h0, 1'b0, 1'b1, "R2 R9 plain write clears all");

      tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule